// File: doc/BRIEF.md
# Micro-Operation Issue Queue with Four-Stage Control Register Chain

This block sits between an instruction decoder and a pipelined datapath. The decoder expands each opcode into several micro-operation words and pushes them, one per cycle at most, into a first-in first-out queue. A chain of four control stage registers drains the queue. On every cycle where the datapath asks the chain to move, each stage passes its word to the next stage. The word in the last stage drops out, and the oldest queued word enters the first stage. All four stages are on the outputs at once, and each one drives the control of its own slice of the datapath.

Each word carries a valid bit. A stage whose valid bit is clear is idle and holds an all-zero payload, called the no-operation word. When the queue has nothing to give at a move, the first stage is loaded with that idle word. The push side is valid/ready. The decoder must hold its word until it sees ready, and ready falls whenever the queue is full. This stops a decoder that produces words faster than the datapath consumes them from overrunning the queue. A flush input clears the queue and every stage in a single cycle.

Top module: `uop_issue_queue`

## Requirements
- R1: While `rst` is high at a clock edge, the queue is emptied and every stage is loaded with the idle word. After reset, `q_empty`=1, `q_full`=0, `in_ready`=1 and `stage_valid`=0.
- R2: On an edge with `advance`=1 and `flush`=0, stage k+1 takes the former contents of stage k for k=1..3, and the old stage 4 word is discarded. Stage 1 takes the oldest queued word, and that word leaves the queue. Stage k is `stage_valid[k-1]` and `stage_word[(k-1)*PAYLOAD_W +: PAYLOAD_W]`.
- R3: On an edge with `advance`=1 while the queue is empty, stage 1 is loaded with the idle word: valid 0 and payload all zeros.
- R4: On an edge with `advance`=0 and `flush`=0, all four stages keep their contents and no word leaves the queue.
- R5: `in_ready` equals the inverse of `q_full`. A word is accepted at an edge only when `in_valid`, `in_ready` are both 1 and `flush` is 0. Accepted words reach stage 1 in the order they were accepted.
- R6: An edge that both accepts a word and removes one leaves the entry count unchanged. `q_empty` is 1 exactly when the count is zero. `q_full` is 1 exactly when the count equals `DEPTH`.
- R7: An edge with `flush`=1 empties the queue and loads the idle word into all four stages. A push offered on that edge is dropped and never reaches a stage.
- R8: A word offered while the queue is full is not stored. After DEPTH accepted words, further offers with `advance`=0 change neither `q_full` nor what later drains into the stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clear queue and stages in one cycle |
| advance | input | 1 | Move the stage chain and take one queued word |
| in_valid | input | 1 | Decoder offers a micro-operation |
| in_ready | output | 1 | Queue can accept the offered word |
| in_payload | input | PAYLOAD_W | Control payload of the offered word |
| q_full | output | 1 | Queue holds DEPTH entries |
| q_empty | output | 1 | Queue holds no entries |
| stage_valid | output | 4 | Valid bit per stage, bit k-1 for stage k |
| stage_word | output | 4*PAYLOAD_W | Payload per stage, stage k at bits (k-1)*PAYLOAD_W upward |

## Verification
The assertions assume that `rst`, `flush`, `advance` and `in_valid` are known (not X or Z) at every clock edge. They also assume that the decoder never offers a word outside the push handshake. Apart from that they accept any sequence, including push, move and flush on the same edge. The stimulus changes every input only at the falling clock edge, from seeded random draws or fixed directed sequences. Flush is kept rare so that the queue regularly reaches both full and empty. Each payload is a running tag, so any reordering, loss or duplication shows up in the stage outputs.

// File: rtl/uopq_pkg.sv
package uopq_pkg;
  localparam int NUM_STAGES = 4;

  typedef enum logic [1:0] {
    CHAIN_HOLD  = 2'd0,
    CHAIN_SHIFT = 2'd1,
    CHAIN_CLEAR = 2'd2
  } chain_op_e;
endpackage

// File: rtl/uopq_fifo.sv
module uopq_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head_data,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] count;

  assign full      = (count == CAP);
  assign empty     = (count == '0);
  assign head_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push && !clear) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
    count <= CAP);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  assert_balanced_count_R6: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !clear) |=> $stable(count));
  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (rst)
    clear |=> empty);
endmodule

// File: rtl/uopq_stage_chain.sv
module uopq_stage_chain
  import uopq_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  chain_op_e                   op,
  input  logic                        head_valid,
  input  logic [WIDTH-1:0]            head_data,
  output logic [NUM_STAGES-1:0]       st_valid,
  output logic [NUM_STAGES*WIDTH-1:0] st_data
);
  logic [NUM_STAGES-1:0] v_q;
  logic [WIDTH-1:0]      d_q [NUM_STAGES];

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    logic             src_v;
    logic [WIDTH-1:0] src_d;

    if (k == 0) begin : g_first
      assign src_v = head_valid;
      assign src_d = head_valid ? head_data : '0;
    end else begin : g_rest
      assign src_v = v_q[k-1];
      assign src_d = d_q[k-1];
    end

    always_ff @(posedge clk) begin
      if (rst || op == CHAIN_CLEAR) begin
        v_q[k] <= 1'b0;
        d_q[k] <= '0;
      end else if (op == CHAIN_SHIFT) begin
        v_q[k] <= src_v;
        d_q[k] <= src_d;
      end
    end

    assign st_valid[k]              = v_q[k];
    assign st_data[k*WIDTH +: WIDTH] = d_q[k];

    if (k > 0) begin : g_chk
      assert_shift_forward_R2: assert property (@(posedge clk) disable iff (rst)
        (op == CHAIN_SHIFT) |=> (v_q[k] == $past(v_q[k-1]) && d_q[k] == $past(d_q[k-1])));
    end

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (op == CHAIN_HOLD) |=> ($stable(v_q[k]) && $stable(d_q[k])));
    assert_idle_is_zero_R3: assert property (@(posedge clk) disable iff (rst)
      !v_q[k] |-> (d_q[k] == '0));
  end

  assert_clear_all_R7: assert property (@(posedge clk) disable iff (rst)
    (op == CHAIN_CLEAR) |=> (v_q == '0));
  assert_empty_fill_R3: assert property (@(posedge clk) disable iff (rst)
    (op == CHAIN_SHIFT && !head_valid) |=> !v_q[0]);
endmodule

// File: rtl/uop_issue_queue.sv
module uop_issue_queue
  import uopq_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int PAYLOAD_W = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          flush,
  input  logic                          advance,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [PAYLOAD_W-1:0]          in_payload,
  output logic                          q_full,
  output logic                          q_empty,
  output logic [NUM_STAGES-1:0]         stage_valid,
  output logic [NUM_STAGES*PAYLOAD_W-1:0] stage_word
);
  logic                 do_push, do_pop;
  logic [PAYLOAD_W-1:0] head;
  chain_op_e            op;

  assign in_ready = !q_full;
  assign do_push  = in_valid && in_ready && !flush;
  assign do_pop   = advance && !q_empty && !flush;

  always_comb begin
    if (flush)        op = CHAIN_CLEAR;
    else if (advance) op = CHAIN_SHIFT;
    else              op = CHAIN_HOLD;
  end

  uopq_fifo #(.DEPTH(DEPTH), .WIDTH(PAYLOAD_W)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .clear     (flush),
    .push      (do_push),
    .push_data (in_payload),
    .pop       (do_pop),
    .head_data (head),
    .full      (q_full),
    .empty     (q_empty)
  );

  uopq_stage_chain #(.WIDTH(PAYLOAD_W)) u_chain (
    .clk        (clk),
    .rst        (rst),
    .op         (op),
    .head_valid (!q_empty),
    .head_data  (head),
    .st_valid   (stage_valid),
    .st_data    (stage_word)
  );

  assert_ready_tracks_full_R5: assert property (@(posedge clk) disable iff (rst)
    in_ready == !q_full);
  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(q_full && q_empty));
  assert_flush_blocks_push_R7: assert property (@(posedge clk) disable iff (rst)
    (flush && in_valid) |=> (q_empty && stage_valid == '0));
endmodule

// File: tb/uop_issue_queue_test.sv
`timescale 1ns/1ps
module uop_issue_queue_test;
  localparam int DEPTH = 8;
  localparam int PW    = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, flush, advance, in_valid, in_ready, q_full, q_empty;
  logic [PW-1:0]   in_payload;
  logic [3:0]      stage_valid;
  logic [4*PW-1:0] stage_word;

  uop_issue_queue #(.DEPTH(DEPTH), .PAYLOAD_W(PW)) uut (
    .clk(clk), .rst(rst), .flush(flush), .advance(advance),
    .in_valid(in_valid), .in_ready(in_ready), .in_payload(in_payload),
    .q_full(q_full), .q_empty(q_empty),
    .stage_valid(stage_valid), .stage_word(stage_word)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [PW-1:0] mq [$];
  logic          mv [4];
  logic [PW-1:0] mp [4];
  logic [PW-1:0] tag = 16'h0100;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    mq.delete();
    for (int k = 0; k < 4; k++) begin mv[k] = 1'b0; mp[k] = '0; end
  endtask

  task automatic model_step(logic f, logic iv, logic [PW-1:0] ip, logic adv);
    bit rdy;
    if (f) begin
      model_reset();
      return;
    end
    rdy = (mq.size() < DEPTH);
    if (adv) begin
      for (int k = 3; k > 0; k--) begin mv[k] = mv[k-1]; mp[k] = mp[k-1]; end
      if (mq.size() > 0) begin mv[0] = 1'b1; mp[0] = mq.pop_front(); end
      else begin mv[0] = 1'b0; mp[0] = '0; end
    end
    if (iv && rdy) mq.push_back(ip);
  endtask

  task automatic compare_all();
    for (int k = 0; k < 4; k++)
      check("R2", {15'd0, stage_valid[k], stage_word[k*PW +: PW]}, {15'd0, mv[k], mp[k]});
    check("R5", {31'd0, in_ready}, {31'd0, mq.size() < DEPTH});
    check("R6", {30'd0, q_empty, q_full}, {30'd0, mq.size() == 0, mq.size() == DEPTH});
  endtask

  task automatic cycle(logic f, logic iv, logic adv);
    flush = f; in_valid = iv; advance = adv; in_payload = tag;
    model_step(f, iv, tag, adv);
    tag = tag + 1'b1;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; flush = 0; advance = 0; in_valid = 0; in_payload = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    // R1 reset state
    check("R1", {28'd0, q_empty, q_full, in_ready, 1'b0}, {28'd0, 1'b1, 1'b0, 1'b1, 1'b0});
    check("R1", {28'd0, stage_valid}, 32'd0);

    // R3: moving with an empty queue fills stage 1 with the idle word
    repeat (5) cycle(0, 0, 1);
    check("R3", {15'd0, stage_valid[0], stage_word[PW-1:0]}, 32'd0);

    // R8: fill with chain held, then keep offering while full
    repeat (DEPTH + 4) cycle(0, 1, 0);
    check("R8", {31'd0, q_full}, 32'd1);
    check("R8", {31'd0, in_ready}, 32'd0);
    // R4: hold keeps stages idle and queue untouched
    repeat (3) cycle(0, 0, 0);
    check("R4", {28'd0, stage_valid}, 32'd0);
    // drain: order shows in stage checks (R5)
    repeat (DEPTH + 4) cycle(0, 0, 1);
    check("R5", {31'd0, q_empty}, 32'd1);

    // R6: reach DEPTH-1, then push+move keeps it below full, then push alone fills
    repeat (DEPTH - 1) cycle(0, 1, 0);
    repeat (6) cycle(0, 1, 1);
    check("R6", {31'd0, q_full}, 32'd0);
    cycle(0, 1, 0);
    check("R6", {31'd0, q_full}, 32'd1);

    // R7: flush with a concurrent push
    cycle(0, 0, 1);
    cycle(1, 1, 1);
    check("R7", {27'd0, q_empty, stage_valid}, {27'd0, 1'b1, 4'd0});
    repeat (4) cycle(0, 0, 1);
    check("R7", {28'd0, stage_valid}, 32'd0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic f, iv, adv;
      f   = ($urandom_range(99) < 2);
      iv  = ($urandom_range(99) < 60);
      adv = ($urandom_range(99) < 45);
      cycle(f, iv, adv);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule